// File: doc/BRIEF.md
# 100BASE-TX Transmit Coding Path

This block is the transmit coding path of a 100 Mb/s twisted-pair PHY. It runs on the 125 MHz bit clock and takes a 4-bit transmit nibble from the MAC side every fifth clock. It emits a signal, `nib_stb`, in the cycle where that nibble is taken. The nibbles are turned into 5-bit code groups. When a frame starts, its first two nibbles are replaced by a start delimiter pair. When the frame ends, an end delimiter pair is sent, followed by idle code groups. A nibble flagged as errored is replaced by a dedicated error code group.

Each code group leaves most significant bit first. Every bit is XORed with the keystream of a free-running 11-bit scrambler. The scrambled bit stream is then coded as a three-level MLT-3 signal. The output is a 2-bit level code that the analog line driver converts into voltage.

Top module: `pcs100_tx_enc`

## Requirements
- R1: `nib_stb` is high for exactly one clock out of every five. `tx_en`, `tx_er` and `txd` are sampled at the clock edge that ends a `nib_stb` cycle.
- R2: Inside a frame, a data nibble is mapped to a 5-bit group with this table (nibble to group, in hex): 0→1E, 1→09, 2→14, 3→15, 4→0A, 5→0B, 6→0E, 7→0F, 8→12, 9→13, A→16, B→17, C→1A, D→1B, E→1C, F→1D.
- R3: A nibble sampled with `tx_en` high, when no frame is active, sends J (11000). The next nibble, if `tx_en` is still high, sends K (10001). The contents of both nibbles are discarded.
- R4: The first nibble sampled with `tx_en` low after a frame sends T (01101). The next nibble sends R (00111) whatever the inputs are, so a nibble offered in that slot is lost. After that, idle (11111) is sent for as long as `tx_en` stays low.
- R5: A data nibble sampled with `tx_er` high sends H (00100) in place of its table group.
- R6: A group sampled at a `nib_stb` edge leaves over the next five clocks, most significant bit first. Its first bit is applied to the line level at the following edge.
- R7: The scrambler state s[10:0] starts at 11'h7FF and advances on every clock. The key bit is k = s[10] ^ s[8], and the next state is {s[9:0], k}. The bit sent is the code bit XOR k.
- R8: Level codes are 00 = zero, 01 = plus, 11 = minus. Every scrambled 1 steps the level along the cycle zero, plus, zero, minus; every scrambled 0 holds it. After reset the first step goes to plus.
- R9: `tx_er` and `txd` have no effect while `tx_en` is low outside a frame: idle is sent.
- R10: During reset the level is zero and `nib_stb` is low. The internal shift register holds ones, so the first five line bits after reset are idle bits.
- R11: If `tx_en` falls on the nibble right after J, then T and R are sent in place of K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txd | input | 4 | Transmit nibble from the MAC side |
| tx_en | input | 1 | Frame-valid qualifier |
| tx_er | input | 1 | Error flag for the current nibble |
| nib_stb | output | 1 | High in the cycle whose closing edge samples the nibble inputs |
| mlt3_lvl | output | 2 | Line level code: 00 zero, 01 plus, 11 minus |

## Verification
The in-line assertions check these properties on every cycle:
- the strobe never lasts two cycles;
- the order of delimiters, with K after J, R after T, and idle after R when the frame has ended;
- that the bit loaded into the shifter is its most significant bit;
- that the scrambler never reaches the all-zero state;
- that the level code never takes the unused value, holds on a 0 and moves only through zero.

The bench's scenarios are needed for the rest:
- the five-cycle strobe spacing;
- the exact table values;
- error substitution;
- the lost nibble in the R slot;
- that tx_er is ignored while idle;
- the exact keystream and level sequence.

The bench checks these by comparing the line level on every cycle against its own model of framing, scrambling and MLT-3 coding.

// File: rtl/pcs100_tx_pkg.sv
package pcs100_tx_pkg;
  localparam int NIB_W  = 4;
  localparam int CG_W   = 5;
  localparam int LFSR_W = 11;

  typedef enum logic [1:0] {FR_IDLE, FR_K, FR_DATA, FR_R} fr_state_t;

  localparam logic [CG_W-1:0] CG_I = 5'b11111;
  localparam logic [CG_W-1:0] CG_J = 5'b11000;
  localparam logic [CG_W-1:0] CG_K = 5'b10001;
  localparam logic [CG_W-1:0] CG_T = 5'b01101;
  localparam logic [CG_W-1:0] CG_R = 5'b00111;
  localparam logic [CG_W-1:0] CG_H = 5'b00100;

  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  function automatic logic [CG_W-1:0] enc4b5b(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic logic lfsr_key(input logic [LFSR_W-1:0] s);
    return s[LFSR_W-1] ^ s[LFSR_W-3];
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], lfsr_key(s)};
  endfunction

  function automatic logic [1:0] mlt3_step(input logic [1:0] lvl, input logic go_pos);
    if (lvl != LV_ZERO) return LV_ZERO;
    return go_pos ? LV_POS : LV_NEG;
  endfunction
endpackage

// File: rtl/pcs100_tx_framer.sv
module pcs100_tx_framer
  import pcs100_tx_pkg::*;
#(
  parameter int BITS_PER_CG = CG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic             nib_stb,
  output logic [CG_W-1:0]  cg_next
);
  localparam int CNT_W = $clog2(BITS_PER_CG);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS_PER_CG - 1);

  logic [CNT_W-1:0] bit_cnt;
  fr_state_t        st, st_nx;

  assign nib_stb = (bit_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      st      <= FR_IDLE;
    end else begin
      bit_cnt <= nib_stb ? '0 : bit_cnt + 1'b1;
      if (nib_stb) st <= st_nx;
    end
  end

  always_comb begin
    st_nx   = st;
    cg_next = CG_I;
    case (st)
      FR_IDLE: if (tx_en) begin cg_next = CG_J; st_nx = FR_K; end
      FR_K: begin
        if (tx_en) begin cg_next = CG_K; st_nx = FR_DATA; end
        else       begin cg_next = CG_T; st_nx = FR_R;    end
      end
      FR_DATA: begin
        if (tx_en) cg_next = tx_er ? CG_H : enc4b5b(txd);
        else begin cg_next = CG_T; st_nx = FR_R; end
      end
      default: begin cg_next = CG_R; st_nx = FR_IDLE; end
    endcase
  end

  // checker-only record of the previous group taken
  logic [CG_W-1:0] prev_cg;
  always_ff @(posedge clk) begin
    if (!rst_n)       prev_cg <= CG_I;
    else if (nib_stb) prev_cg <= cg_next;
  end

  assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |=> !nib_stb);
  assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && prev_cg == CG_J && tx_en) |-> cg_next == CG_K);
  assert_t_then_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && prev_cg == CG_T) |-> cg_next == CG_R);
  assert_idle_after_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && prev_cg == CG_R && !tx_en) |-> cg_next == CG_I);
  assert_no_k_on_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_stb && prev_cg == CG_J && !tx_en) |-> cg_next == CG_T);
endmodule

// File: rtl/pcs100_tx_serializer.sv
module pcs100_tx_serializer
  import pcs100_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CG_W-1:0] cg_in,
  output logic            ser_bit
);
  logic [CG_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '1;
    else if (load) sh <= cg_in;
    else           sh <= {sh[CG_W-2:0], 1'b1};
  end

  assign ser_bit = sh[CG_W-1];

  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_bit == $past(cg_in[CG_W-1]));
endmodule

// File: rtl/pcs100_tx_scrambler.sv
module pcs100_tx_scrambler
  import pcs100_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  output logic key_bit,
  output logic scr_bit
);
  logic [LFSR_W-1:0] s;

  always_ff @(posedge clk) begin
    if (!rst_n) s <= SEED;
    else        s <= lfsr_adv(s);
  end

  assign key_bit = lfsr_key(s);
  assign scr_bit = in_bit ^ key_bit;

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s != '0);
endmodule

// File: rtl/pcs100_tx_mlt3.sv
module pcs100_tx_mlt3
  import pcs100_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_bit,
  output logic [1:0] lvl
);
  logic go_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl    <= LV_ZERO;
      go_pos <= 1'b1;
    end else if (in_bit) begin
      lvl <= mlt3_step(lvl, go_pos);
      if (lvl == LV_ZERO) go_pos <= ~go_pos;
    end
  end

  assert_lvl_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl != 2'b10);
  assert_hold_on_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_bit)) |-> $stable(lvl));
  assert_step_via_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> (lvl == LV_ZERO || $past(lvl) == LV_ZERO));
endmodule

// File: rtl/pcs100_tx_enc.sv
module pcs100_tx_enc
  import pcs100_tx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SCR_SEED = 11'h7FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic             nib_stb,
  output logic [1:0]       mlt3_lvl
);
  logic [CG_W-1:0] cg_next;
  logic            ser_bit;
  logic            key_bit;
  logic            scr_bit;

  pcs100_tx_framer #(.BITS_PER_CG(CG_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
    .nib_stb(nib_stb), .cg_next(cg_next)
  );

  pcs100_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .load(nib_stb), .cg_in(cg_next), .ser_bit(ser_bit)
  );

  pcs100_tx_scrambler #(.SEED(SCR_SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .in_bit(ser_bit), .key_bit(key_bit), .scr_bit(scr_bit)
  );

  pcs100_tx_mlt3 u_mlt3 (
    .clk(clk), .rst_n(rst_n), .in_bit(scr_bit), .lvl(mlt3_lvl)
  );

  assert_key_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_bit != ser_bit) == key_bit);
endmodule

// File: tb/tb_pcs100_tx_enc.sv
module tb_pcs100_tx_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic       nib_stb;
  logic [1:0] mlt3_lvl;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;
  bit done   = 1'b0;
  string scn = "reset";

  always #5 clk = ~clk;

  pcs100_tx_enc dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
    .nib_stb(nib_stb), .mlt3_lvl(mlt3_lvl)
  );

  // reference model state
  bit    qb[$];
  string qt[$];
  logic [10:0] m_s = 11'h7FF;
  int    phase = 0;
  logic [1:0] exp_lvl = 2'b00;
  string last_tag = "R10";
  int    mst = 0;
  int    gap = 0;
  bit    seen_stb = 1'b0;

  function automatic logic [4:0] tbl(input logic [3:0] d);
    logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                           5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    return t[d];
  endfunction

  task automatic push_grp(input logic [4:0] g, input string tag);
    for (int i = 4; i >= 0; i--) begin
      qb.push_back(g[i]);
      qt.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      bit b;
      bit k;
      string tg;
      checks++;
      if (mlt3_lvl !== exp_lvl) begin
        fails++;
        $display("FAIL %s (R6 R7 R8) scn=%s t=%0t: level got %b exp %b",
                 last_tag, scn, $time, mlt3_lvl, exp_lvl);
      end
      if (nib_stb) begin
        if (seen_stb) begin
          checks++;
          if (gap != 5) begin
            fails++;
            $display("FAIL R1 strobe spacing got %0d exp 5", gap);
          end
        end
        seen_stb = 1'b1;
        gap = 0;
      end
      gap++;
      if (qb.size() > 0) begin b = qb.pop_front(); tg = qt.pop_front(); end
      else begin b = 1'b1; tg = "R10"; end
      if (nib_stb) begin
        case (mst)
          0: if (tx_en) begin push_grp(5'b11000, "R3"); mst = 1; end
             else push_grp(5'b11111, tx_er ? "R9" : "R4");
          1: if (tx_en) begin push_grp(5'b10001, "R3"); mst = 2; end
             else begin push_grp(5'b01101, "R11"); mst = 3; end
          2: if (!tx_en) begin push_grp(5'b01101, "R4"); mst = 3; end
             else if (tx_er) push_grp(5'b00100, "R5");
             else push_grp(tbl(txd), "R2");
          default: begin push_grp(5'b00111, "R4"); mst = 0; end
        endcase
      end
      k = m_s[10] ^ m_s[8];
      m_s = {m_s[9:0], k};
      if (b ^ k) phase = (phase + 1) % 4;
      exp_lvl = (phase == 1) ? 2'b01 : (phase == 3) ? 2'b11 : 2'b00;
      last_tag = tg;
    end
  end

  task automatic put(input bit en, input logic [3:0] d, input bit er);
    @(posedge clk); #1;
    while (!nib_stb) begin @(posedge clk); #1; end
    tx_en = en; txd = d; tx_er = er;
  endtask

  task automatic test_reset;
    scn = "reset";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (mlt3_lvl !== 2'b00 || nib_stb !== 1'b0) begin
        fails++;
        $display("FAIL R10 reset outputs got lvl=%b stb=%b exp lvl=00 stb=0", mlt3_lvl, nib_stb);
      end
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    run = 1'b1;
  endtask

  task automatic test_idle_err_ignored;
    scn = "idle_R9";
    for (int i = 0; i < 6; i++) put(1'b0, 4'(i * 3), 1'b1);
    put(1'b0, 4'h0, 1'b0);
  endtask

  task automatic test_full_frame;
    scn = "frame_R2_R3_R4";
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'h5, 1'b0);
    for (int i = 0; i < 16; i++) put(1'b1, 4'(i), 1'b0);
    put(1'b0, 4'h0, 1'b0);
    for (int i = 0; i < 3; i++) put(1'b0, 4'h0, 1'b0);
  endtask

  task automatic test_error_frame;
    scn = "error_R5";
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'hD, 1'b0);
    put(1'b1, 4'hA, 1'b0);
    put(1'b1, 4'h3, 1'b1);
    put(1'b1, 4'hF, 1'b1);
    put(1'b1, 4'h6, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    put(1'b0, 4'h0, 1'b0);
  endtask

  task automatic test_short_frame;
    scn = "short_R11";
    put(1'b1, 4'h5, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    put(1'b0, 4'h0, 1'b0);
  endtask

  task automatic test_back_to_back;
    scn = "b2b_R4";
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'h9, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    put(1'b1, 4'h7, 1'b0);
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'h5, 1'b0);
    put(1'b1, 4'hC, 1'b0);
    put(1'b1, 4'h0, 1'b0);
    put(1'b0, 4'h0, 1'b0);
    for (int i = 0; i < 4; i++) put(1'b0, 4'h0, 1'b0);
  endtask

  initial begin
    test_reset();
    test_idle_err_ignored();
    test_full_frame();
    test_error_frame();
    test_short_frame();
    test_back_to_back();
    repeat (20) @(posedge clk);
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired scn=%s", scn);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule